// File: doc/BRIEF.md
# Programmable-Priority Interrupt Resolver

This block decides which one of many simultaneous reset and interrupt requests the processor services next. Six non-maskable requests (resets and traps) always outrank fifteen maskable requests. Among the maskable requests a fixed order applies, but a 4-bit promotion field can lift any single maskable source to the top of the maskable group. Each maskable request needs its local enable, and the global mask bit must be clear. The result is a valid flag and a 5-bit source index, and the index selects that source's fixed vector.

The resolver path is purely combinational, from the request, enable and mask inputs to the winner. The promotion field is the only state. It can be written only while the global mask is set, which keeps the arbitration order from changing under an interrupt that is being taken. All ports are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_resolver`

## Requirements
- R1: While reset is held, and right after it, `sel_q` reads binary 0110. With that value the external IRQ (maskable slot 0) is the top maskable source.
- R2: If any `nmi_req` bit is set, `win_valid` is 1 and `win_idx` is the lowest set bit position of `nmi_req`. Bit 0 is power-on/pin reset, 1 is clock-monitor reset, 2 is watchdog reset, 3 is the non-maskable external interrupt, 4 is the illegal-opcode trap and 5 is the software interrupt. `gmask`, `msk_req` and `msk_en` have no effect on this result.
- R3: While `gmask` is 1 and no `nmi_req` bit is set, `win_valid` is 0, whatever the maskable requests are.
- R4: With no promotion in effect, the maskable winner is the lowest slot k where both `msk_req[k]` and `msk_en[k]` are set. Its index is 6+k. Slots in order from 0 are: IRQ, real-time, IC1, IC2, IC3, OC1, OC2, OC3, OC4, IC4/OC5, timer overflow, pulse-accumulator overflow, pulse-accumulator edge, SPI, SCI.
- R5: The promoted slot is p = (`sel_q` − 6) mod 16. Code 0101 gives p = 15, which means no promotion. If slot p is pending and enabled, it wins over every other maskable slot. All other slots keep the R4 order.
- R6: A promoted slot that has `msk_en` clear, or that is pending while `gmask` is set, does not win. Arbitration then falls to the next eligible source.
- R7: A write (`sel_we` = 1) with `gmask` = 1 loads `sel_wdata` into `sel_q` at the next rising clock edge.
- R8: A write with `gmask` = 0 is ignored. `sel_q` keeps its value.
- R9: When no source wins, `win_valid` is 0 and `win_idx` is 0.
- R10: Promotion changes only the arbitration order. A winning maskable slot k always reports index 6+k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req | input | 6 | Non-maskable requests, bit 0 highest |
| msk_req | input | 15 | Maskable requests, by slot |
| msk_en | input | 15 | Local enables, by slot |
| gmask | input | 1 | Global maskable-interrupt mask, 1 = masked |
| sel_we | input | 1 | Promotion-field write strobe |
| sel_wdata | input | 4 | Promotion-field write value |
| sel_q | output | 4 | Current promotion-field value |
| win_valid | output | 1 | A source is selected |
| win_idx | output | 5 | Winning source index (0–5 non-maskable, 6–20 maskable) |

## Verification
The promotion field is the only state in the block. A corrupted or wrongly accepted field value shows up on `sel_q` in the cycle right after the bad write. It also changes `win_idx` whenever the promoted slot and a lower-ranked slot are eligible together. The bench sweeps every field code and, in each cycle, compares the winner and the field against a behavioural model. A stale or misloaded field is therefore caught within one clock of the first competing request pattern.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int N_NMI     = 6;
  localparam int N_MSK     = 15;
  localparam int SEL_W     = 4;
  localparam int IDX_W     = 5;
  localparam int MSK_BASE  = N_NMI;
  localparam logic [SEL_W-1:0] SEL_RESET = 4'b0110;

  // Map a field code to a maskable slot; a result >= N_MSK means no promotion.
  function automatic logic [SEL_W-1:0] sel_to_slot(input logic [SEL_W-1:0] code);
    return code - SEL_RESET;
  endfunction
endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int W  = 15,
  parameter int OW = 5
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [OW-1:0] pos
);
  always_comb begin
    found = |vec;
    pos   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) pos = OW'(i);
    end
  end
endmodule

// File: rtl/irq_sel_reg.sv
module irq_sel_reg #(
  parameter int                SEL_W     = 4,
  parameter logic [SEL_W-1:0]  SEL_RESET = 4'b0110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wdata,
  input  logic             gmask,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sel_q <= SEL_RESET;
    else if (we && gmask)  sel_q <= wdata;
  end

  // R7: a write while masked is taken
  assert_wr_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && gmask) |=> (sel_q == $past(wdata)));

  // R8: a write while unmasked is dropped
  assert_wr_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !gmask) |=> $stable(sel_q));

  // R1/R8: no write, no change
  assert_sel_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!we) |=> $stable(sel_q));
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
#(
  parameter int NN = N_NMI,
  parameter int NM = N_MSK,
  parameter int SW = SEL_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NN-1:0] nmi_req,
  input  logic [NM-1:0] msk_req,
  input  logic [NM-1:0] msk_en,
  input  logic          gmask,
  input  logic          sel_we,
  input  logic [SW-1:0] sel_wdata,
  output logic [SW-1:0] sel_q,
  output logic          win_valid,
  output logic [IW-1:0] win_idx
);
  localparam logic [IW-1:0] BASE = IW'(NN);

  logic [NM-1:0] eligible;
  logic [NM-1:0] promo_oh;
  logic [SW-1:0] slot;
  logic          nmi_found, msk_found, promo_hit;
  logic [IW-1:0] nmi_pos, msk_pos, promo_pos;

  irq_sel_reg #(.SEL_W(SW), .SEL_RESET(SW'(SEL_RESET))) u_sel (
    .clk(clk), .rst_n(rst_n), .we(sel_we), .wdata(sel_wdata),
    .gmask(gmask), .sel_q(sel_q)
  );

  assign eligible = msk_req & msk_en & {NM{~gmask}};
  assign slot     = sel_to_slot(sel_q);

  for (genvar k = 0; k < NM; k++) begin : g_promo
    assign promo_oh[k] = (slot == SW'(k));
  end

  irq_first_set #(.W(NN), .OW(IW)) u_nmi (
    .vec(nmi_req), .found(nmi_found), .pos(nmi_pos));
  irq_first_set #(.W(NM), .OW(IW)) u_msk (
    .vec(eligible), .found(msk_found), .pos(msk_pos));
  irq_first_set #(.W(NM), .OW(IW)) u_pro (
    .vec(eligible & promo_oh), .found(promo_hit), .pos(promo_pos));

  always_comb begin
    win_valid = nmi_found | msk_found;
    if (nmi_found)      win_idx = nmi_pos;
    else if (promo_hit) win_idx = BASE + promo_pos;
    else if (msk_found) win_idx = BASE + msk_pos;
    else                win_idx = '0;
  end

  // R2: any non-maskable request wins over all maskable ones
  assert_nmi_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|nmi_req) |-> (win_valid && (win_idx < BASE) && nmi_req[win_idx[2:0]]));

  // R3: the global mask blocks every maskable source
  assert_gmask_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask && !(|nmi_req)) |-> !win_valid);

  // R9: idle output reads zero
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_valid) |-> (win_idx == '0));

  // R6/R10: a maskable winner is pending, enabled and unmasked at its own index
  assert_msk_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_idx >= BASE) |->
      (!gmask && ((((msk_req & msk_en) >> (win_idx - BASE)) & NM'(1)) != '0)));
endmodule

// File: tb/irq_resolver_tb.sv
module irq_resolver_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  nmi_req = '0;
  logic [14:0] msk_req = '0, msk_en = '0;
  logic        gmask = 1;
  logic        sel_we = 0;
  logic [3:0]  sel_wdata = '0;
  logic [3:0]  sel_q;
  logic        win_valid;
  logic [4:0]  win_idx;

  int vecs = 0, errs = 0;
  int m_sel = 6;
  bit last_rejected = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .msk_req(msk_req),
    .msk_en(msk_en), .gmask(gmask), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .sel_q(sel_q), .win_valid(win_valid), .win_idx(win_idx)
  );

  // Behavioural reference: ranked list of slots, walked in order.
  function automatic void ref_pick(output bit v, output int idx, output string tag);
    int order[$];
    int p;
    v = 0; idx = 0; tag = "R9";
    for (int i = 0; i < 6; i++)
      if (nmi_req[i]) begin v = 1; idx = i; tag = "R2"; return; end
    if (gmask) begin tag = "R3"; return; end
    p = (m_sel + 10) % 16;
    if (p < 15) order.push_back(p);
    for (int k = 0; k < 15; k++) if (k != p) order.push_back(k);
    foreach (order[j]) begin
      if (msk_req[order[j]] && msk_en[order[j]]) begin
        v = 1; idx = 6 + order[j];
        tag = (order[j] == p) ? "R5" : "R4";
        return;
      end
    end
  endfunction

  task automatic check_now(input string extra);
    bit ev; int ei; string tg;
    ref_pick(ev, ei, tg);
    vecs++;
    if (win_valid !== ev || (ev && win_idx !== 5'(ei)) || (!ev && win_idx !== 5'd0)) begin
      errs++;
      $display("FAIL %s%s: valid/idx = %0b/%0d, expected %0b/%0d", tg, extra,
               win_valid, win_idx, ev, ev ? ei : 0);
    end
    vecs++;
    if (sel_q !== 4'(m_sel)) begin
      errs++;
      $display("FAIL %s: sel_q = %0d, expected %0d",
               last_rejected ? "R8" : "R7", sel_q, m_sel);
    end
  endtask

  // One cycle: drive at negedge, check before posedge, update model at posedge.
  task automatic cycle(input logic [5:0] n, input logic [14:0] r, input logic [14:0] e,
                       input logic g, input logic we, input logic [3:0] wd,
                       input string extra);
    @(negedge clk);
    nmi_req = n; msk_req = r; msk_en = e; gmask = g; sel_we = we; sel_wdata = wd;
    #5;
    check_now(extra);
    @(posedge clk);
    if (we) begin
      if (g) begin m_sel = wd; last_rejected = 0; end
      else last_rejected = 1;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    // R1: reset value
    #25;
    vecs++;
    if (sel_q !== 4'b0110) begin
      errs++; $display("FAIL R1: sel_q = %0d, expected 6", sel_q);
    end
    @(negedge clk); rst_n = 1;
    cycle('0, 15'h0001, 15'h7fff, 0, 0, 0, " (R1 IRQ top)");
    cycle('0, 15'h0000, 15'h7fff, 0, 0, 0, " (R9 idle)");
    cycle(6'b101000, 15'h7fff, 15'h7fff, 0, 0, 0, " (R2)");
    cycle('0, 15'h7fff, 15'h7fff, 1, 0, 0, " (R3)");
    // R8: write while unmasked is ignored
    cycle('0, '0, '0, 0, 1, 4'd9, " (R8 write)");
    cycle('0, '0, '0, 0, 0, 0, " (R8 after)");
    // R7 + R6: promote slot 3, but its enable is clear -> slot 5 wins
    cycle('0, '0, '0, 1, 1, 4'd9, " (R7 write)");
    cycle('0, 15'h0028, 15'h7ff7, 0, 0, 0, " (R6 local enable)");
    cycle('0, 15'h0028, 15'h7fff, 0, 0, 0, " (R5 promoted)");
    // R10: promote slot 4, it alone wins and keeps index 10
    cycle('0, '0, '0, 1, 1, 4'd10, " (R10 write)");
    cycle('0, 15'h0010, 15'h7fff, 0, 0, 0, " (R10 index)");
    // R5: code 0101 -> no promotion
    cycle('0, '0, '0, 1, 1, 4'd5, " (R5 none write)");
    cycle('0, 15'h4002, 15'h7fff, 0, 0, 0, " (R5 code 0101)");
    // Sweep every code with random traffic
    for (int c = 0; c < 16; c++) begin
      cycle('0, '0, '0, 1, 1, 4'(c), " (sweep write)");
      for (int t = 0; t < 300; t++) begin
        logic [5:0] n;
        n = (($urandom % 8) == 0) ? 6'($urandom) : 6'd0;
        cycle(n, 15'($urandom), 15'($urandom), 1'($urandom), 1'(($urandom % 16) == 0),
              4'($urandom), " (sweep)");
      end
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule